// File: doc/BRIEF.md
# Register-File Stack Pointer Unit

This block generates addresses for a 128-byte on-chip register file that also holds a hardware stack. An 8-bit stack pointer climbs by one on each push strobe and falls by one on each pop strobe. Every cycle, the block reports the register-file location that the current push or pop should touch. It also registers the two byte addresses used by instructions that work on a register pair.

A mode input selects how the pointer behaves when it is popped past the bottom of the file. The clean mode pins the pointer at 0x00. The legacy mode reproduces an older underflow quirk: the first illegal pop is absorbed, and each later one counts one step further below zero. Pushes must then pay that depth back before the pointer rises again. Pair addressing wraps at the top of physical memory, 0x7F, and never at 0xFF. The storage array and instruction decoding live outside the block.

Top module: `rf_stack_addr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `sp_o` is 0x00, `ovf_o` is 0, both pair outputs are 0x00, and no underflow depth is remembered.
- R2: A push alone raises `sp_o` by one, and a pop alone lowers it by one, visible after the next rising clock edge. Push and pop together leave `sp_o` unchanged.
- R3: With `mode_i` = 0 (saturating), a pop at 0x00 leaves `sp_o` at 0x00, however many such pops occur. The first push afterwards gives 0x01.
- R4: With `mode_i` = 1 (legacy), after n pops issued at 0x00, `sp_o` stays 0x00 through the next n-1 pushes, and the push after those gives 0x01. The remembered depth saturates at 255.
- R5: In legacy mode, while the remembered depth is non-zero (two or more illegal pops not yet paid back), `acc_addr_o` is 0x00 whatever the strobes are.
- R6: A push at 0x7F moves `sp_o` to 0x00, and `ovf_o` is high for exactly the one cycle that follows that edge.
- R7: `acc_addr_o` is combinational. For a push alone it is the location the pointer moves to (`sp_o`+1, with 0x7F wrapping to 0x00). Otherwise it is `sp_o`.
- R8: On the edge after `pair_req_i`, `pair_first_o` takes `pair_base_i` modulo 128 and `pair_second_o` takes one less, with 0x00 wrapping to 0x7F. Without a request, both hold their values.
- R9: Spending a cycle in saturating mode clears any legacy underflow history, so a later push in legacy mode from 0x00 gives 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = saturating underflow, 1 = legacy underflow |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| pair_req_i | input | 1 | Capture a register-pair address |
| pair_base_i | input | 8 | Base byte address of the pair |
| sp_o | output | 8 | Current stack pointer |
| acc_addr_o | output | 8 | Register-file location for this cycle's stack access |
| ovf_o | output | 1 | One-cycle flag after a push wrapped at 0x7F |
| pair_first_o | output | 8 | First (base) byte of the pair |
| pair_second_o | output | 8 | Second byte, one below the base |

## Verification
Results fall due at one of two times. The access address is combinational from the present pointer and strobes, so it is due in the same cycle. The pointer, overflow flag and pair outputs are due one clock edge after the strobe or request that changes them. The bench applies inputs after a falling edge and samples the access address 1 ns later, against a reference model that still holds the pre-edge state. At the next falling edge it compares the registered outputs against the model once the model has been advanced.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   typedef enum logic {
      RFS_SAT    = 1'b0,
      RFS_LEGACY = 1'b1
   } rfs_mode_e;
endpackage

// File: rtl/rfs_sp_core.sv
module rfs_sp_core
   import rfs_pkg::*;
#(
   parameter int PTR_W    = 8,
   parameter int RF_DEPTH = 128,
   parameter int UND_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rfs_mode_e        mode,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] sp,
   output logic [UND_W-1:0] und_depth,
   output logic             ovf
);
   localparam logic [PTR_W-1:0] TOP     = PTR_W'(RF_DEPTH - 1);
   localparam logic [UND_W-1:0] UND_MAX = '1;
   localparam bit               POW2    = (RF_DEPTH & (RF_DEPTH - 1)) == 0;

   logic             do_push, do_pop;
   logic [PTR_W-1:0] sp_inc, sp_n;
   logic [UND_W-1:0] und_n;
   logic             pin, pin_n, ovf_n;

   assign do_push = push & ~pop;
   assign do_pop  = pop & ~push;

   generate
      if (POW2) begin : g_wrap_mask
         assign sp_inc = (sp + PTR_W'(1)) & TOP;
      end else begin : g_wrap_cmp
         assign sp_inc = (sp == TOP) ? '0 : sp + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      sp_n  = sp;
      und_n = und_depth;
      pin_n = pin;
      ovf_n = 1'b0;
      if (mode == RFS_SAT) begin
         und_n = '0;
         pin_n = 1'b0;
         if (do_push) begin
            sp_n  = sp_inc;
            ovf_n = (sp == TOP);
         end else if (do_pop && sp != '0) begin
            sp_n = sp - PTR_W'(1);
         end
      end else begin
         if (do_push) begin
            if (und_depth != '0) begin
               und_n = und_depth - UND_W'(1);
            end else begin
               pin_n = 1'b0;
               sp_n  = sp_inc;
               ovf_n = (sp == TOP);
            end
         end else if (do_pop) begin
            if (sp != '0)                sp_n  = sp - PTR_W'(1);
            else if (!pin)               pin_n = 1'b1;
            else if (und_depth != UND_MAX) und_n = und_depth + UND_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp        <= '0;
         und_depth <= '0;
         pin       <= 1'b0;
         ovf       <= 1'b0;
      end else begin
         sp        <= sp_n;
         und_depth <= und_n;
         pin       <= pin_n;
         ovf       <= ovf_n;
      end
   end

   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(sp)); // R2
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && sp != '0) |=> (sp == $past(sp) - PTR_W'(1))); // R2
   AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RFS_SAT && do_pop && sp == '0) |=> (sp == '0)); // R3
   AST_LEG_PAYBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RFS_LEGACY && do_push && und_depth != '0) |=> (sp == '0)); // R4
   AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (sp == '0)); // R6
   AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> !ovf); // R6
   AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RFS_SAT) |=> (und_depth == '0)); // R9
endmodule

// File: rtl/rfs_acc_addr.sv
module rfs_acc_addr #(
   parameter int PTR_W    = 8,
   parameter int RF_DEPTH = 128,
   parameter int UND_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [PTR_W-1:0] sp,
   input  logic [UND_W-1:0] und_depth,
   output logic [PTR_W-1:0] acc_addr
);
   localparam logic [PTR_W-1:0] TOP = PTR_W'(RF_DEPTH - 1);

   logic [PTR_W-1:0] next_loc;

   assign next_loc = (sp == TOP) ? '0 : sp + PTR_W'(1);

   always_comb begin
      if (und_depth != '0)     acc_addr = '0;
      else if (push && !pop)   acc_addr = next_loc;
      else                     acc_addr = sp;
   end

   AST_ACC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (und_depth != '0) |-> (acc_addr == '0)); // R5
   AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_addr <= TOP); // R7
endmodule

// File: rtl/rfs_pair_addr.sv
module rfs_pair_addr #(
   parameter int PTR_W    = 8,
   parameter int RF_DEPTH = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [PTR_W-1:0] base,
   output logic [PTR_W-1:0] first,
   output logic [PTR_W-1:0] second
);
   localparam logic [PTR_W-1:0] TOP  = PTR_W'(RF_DEPTH - 1);
   localparam bit               POW2 = (RF_DEPTH & (RF_DEPTH - 1)) == 0;

   logic [PTR_W-1:0] folded, below;

   generate
      if (POW2) begin : g_fold_mask
         assign folded = base & TOP;
      end else begin : g_fold_mod
         assign folded = PTR_W'(int'(base) % RF_DEPTH);
      end
   endgenerate

   assign below = (folded == '0) ? TOP : folded - PTR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first  <= '0;
         second <= '0;
      end else if (req) begin
         first  <= folded;
         second <= below;
      end
   end

   AST_PAIR_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (second == ((first == '0) ? TOP : first - PTR_W'(1)))); // R8
   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> ($stable(first) && $stable(second))); // R8
endmodule

// File: rtl/rf_stack_addr.sv
module rf_stack_addr
   import rfs_pkg::*;
#(
   parameter int PTR_W    = 8,
   parameter int RF_DEPTH = 128,
   parameter int UND_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             pair_req_i,
   input  logic [PTR_W-1:0] pair_base_i,
   output logic [PTR_W-1:0] sp_o,
   output logic [PTR_W-1:0] acc_addr_o,
   output logic             ovf_o,
   output logic [PTR_W-1:0] pair_first_o,
   output logic [PTR_W-1:0] pair_second_o
);
   generate
      if (RF_DEPTH < 2 || RF_DEPTH > (1 << PTR_W)) begin : g_bad_depth
         $error("rf_stack_addr: RF_DEPTH must lie in 2 .. 2**PTR_W");
      end
      if (UND_W < 1) begin : g_bad_und
         $error("rf_stack_addr: UND_W must be at least 1");
      end
   endgenerate

   rfs_mode_e        mode;
   logic [UND_W-1:0] und_depth;

   assign mode = rfs_mode_e'(mode_i);

   rfs_sp_core #(.PTR_W(PTR_W), .RF_DEPTH(RF_DEPTH), .UND_W(UND_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .push      (push_i),
      .pop       (pop_i),
      .sp        (sp_o),
      .und_depth (und_depth),
      .ovf       (ovf_o)
   );

   rfs_acc_addr #(.PTR_W(PTR_W), .RF_DEPTH(RF_DEPTH), .UND_W(UND_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_i),
      .pop       (pop_i),
      .sp        (sp_o),
      .und_depth (und_depth),
      .acc_addr  (acc_addr_o)
   );

   rfs_pair_addr #(.PTR_W(PTR_W), .RF_DEPTH(RF_DEPTH)) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (pair_req_i),
      .base   (pair_base_i),
      .first  (pair_first_o),
      .second (pair_second_o)
   );
endmodule

// File: tb/rf_stack_addr_tb.sv
`timescale 1ns/1ps
module rf_stack_addr_tb;
   localparam int TOPV = 127;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_i = 1'b0, push_i = 1'b0, pop_i = 1'b0, pair_req_i = 1'b0;
   logic [7:0] pair_base_i = 8'h00;
   logic [7:0] sp_o, acc_addr_o, pair_first_o, pair_second_o;
   logic       ovf_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model state
   int m_sp = 0, m_und = 0, m_first = 0, m_second = 0;
   bit m_pin = 1'b0, m_ovf = 1'b0;

   always #4 clk = ~clk;

   rf_stack_addr u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .push_i(push_i), .pop_i(pop_i),
      .pair_req_i(pair_req_i), .pair_base_i(pair_base_i), .sp_o(sp_o),
      .acc_addr_o(acc_addr_o), .ovf_o(ovf_o), .pair_first_o(pair_first_o),
      .pair_second_o(pair_second_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_acc(bit ps, bit pp);
      if (m_und != 0) return 0;
      if (ps && !pp) return (m_sp == TOPV) ? 0 : m_sp + 1;
      return m_sp;
   endfunction

   task automatic model_adv(bit md, bit ps, bit pp, bit rq, int base);
      m_ovf = 1'b0;
      if (rq) begin
         m_first  = base % 128;
         m_second = (m_first == 0) ? TOPV : m_first - 1;
      end
      if (!md) begin
         m_und = 0; m_pin = 1'b0;
         if (ps && !pp) begin m_ovf = (m_sp == TOPV); m_sp = (m_sp == TOPV) ? 0 : m_sp + 1; end
         else if (pp && !ps && m_sp > 0) m_sp--;
      end else begin
         if (ps && !pp) begin
            if (m_und > 0) m_und--;
            else begin m_pin = 1'b0; m_ovf = (m_sp == TOPV); m_sp = (m_sp == TOPV) ? 0 : m_sp + 1; end
         end else if (pp && !ps) begin
            if (m_sp > 0) m_sp--;
            else if (!m_pin) m_pin = 1'b1;
            else if (m_und < 255) m_und++;
         end
      end
   endtask

   // Registered outputs are checked at the falling edge after the change.
   task automatic chk_regs(input string tag);
      chk({tag, " R2/R3/R4 sp"}, int'(sp_o), m_sp);
      chk("R6 ovf", int'(ovf_o), int'(m_ovf));
      chk("R8 pair first", int'(pair_first_o), m_first);
      chk("R8 pair second", int'(pair_second_o), m_second);
   endtask

   task automatic step(input string tag, input bit md, input bit ps, input bit pp,
                       input bit rq, input int base);
      @(negedge clk);
      chk_regs(tag);
      mode_i = md; push_i = ps; pop_i = pp; pair_req_i = rq; pair_base_i = 8'(base);
      #1;
      chk("R5/R7 acc", int'(acc_addr_o), exp_acc(ps, pp));
      model_adv(md, ps, pp, rq, base);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 sp in reset", int'(sp_o), 0);
      chk("R1 ovf in reset", int'(ovf_o), 0);
      chk("R1 pair in reset", int'(pair_second_o), 0);
      rst_n = 1'b1;
      step("R1", 0, 0, 0, 0, 0);

      // R2: basic up/down and simultaneous strobes
      for (int i = 0; i < 5; i++) step("R2", 0, 1, 0, 0, 0);
      step("R2", 0, 1, 1, 0, 0);
      step("R2", 0, 0, 1, 0, 0);
      step("R2", 0, 0, 0, 0, 0);
      chk("R2 sp after 5 up 1 down", int'(sp_o), 4);

      // R3: saturating floor
      for (int i = 0; i < 10; i++) step("R3", 0, 0, 1, 0, 0);
      step("R3", 0, 1, 0, 0, 0);
      step("R3", 0, 0, 0, 0, 0);
      chk("R3 first push after floor", int'(sp_o), 1);
      step("R3", 0, 0, 1, 0, 0);

      // R4/R5: legacy, 6 illegal pops then 5 pushes stay at 0
      for (int i = 0; i < 6; i++) step("R4", 1, 0, 1, 0, 0);
      for (int i = 0; i < 5; i++) step("R4 R5", 1, 1, 0, 0, 0);
      step("R4", 1, 0, 0, 0, 0);
      chk("R4 still zero after n-1 pushes", int'(sp_o), 0);
      step("R4", 1, 1, 0, 0, 0);
      step("R4", 1, 0, 0, 0, 0);
      chk("R4 push after payback", int'(sp_o), 1);
      step("R4", 1, 0, 1, 0, 0);

      // R9: saturating cycle clears legacy history
      for (int i = 0; i < 4; i++) step("R9", 1, 0, 1, 0, 0);
      step("R9", 0, 0, 0, 0, 0);
      step("R9", 1, 1, 0, 0, 0);
      step("R9", 1, 0, 0, 0, 0);
      chk("R9 history cleared", int'(sp_o), 1);

      // R6: climb to top and wrap
      for (int i = 0; i < 126; i++) step("R6", 0, 1, 0, 0, 0);
      step("R6", 0, 0, 0, 0, 0);
      chk("R6 at top", int'(sp_o), TOPV);
      step("R6 R7", 0, 1, 0, 0, 0);
      step("R6", 0, 0, 0, 0, 0);
      chk("R6 wrapped", int'(sp_o), 0);
      chk("R6 flag", int'(ovf_o), 1);
      step("R6", 0, 0, 0, 0, 0);
      chk("R6 flag one cycle", int'(ovf_o), 0);

      // R8: pair corner cases
      step("R8", 0, 0, 0, 1, 8'h00);
      step("R8", 0, 0, 0, 0, 8'h33);
      chk("R8 base zero wraps to 7F", int'(pair_second_o), TOPV);
      step("R8", 0, 0, 0, 1, 8'h85);
      step("R8", 0, 0, 0, 0, 8'h10);
      chk("R8 folded base", int'(pair_first_o), 5);
      chk("R8 folded second", int'(pair_second_o), 4);

      // constrained random, legacy runs bias toward popping
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         bit md, ps, pp, rq;
         md = ((i / 500) % 2) == 1;
         pp = ($urandom % 100) < (md ? 60 : 45);
         ps = ($urandom % 100) < 45;
         rq = ($urandom % 4) == 0;
         step("random", md, ps, pp, rq, int'($urandom % 256));
      end
      step("final", 0, 0, 0, 0, 0);
      @(negedge clk);
      chk_regs("final");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule